// File: doc/BRIEF.md
# Seed Instruction Byte Decoder

This block is a sequential front-end decoder for the hardware seed-read instruction. It takes one instruction byte per cycle, qualified by a valid strobe. Cycles without the strobe are bubbles, and the decoder holds its place through them. Before the two-byte opcode it collects the prefixes that matter to this instruction: operand-size override, LOCK, the two repeat prefixes and, in 64-bit mode only, REX. It then reads the ModRM byte. Once the instruction ends, it emits one result for it, either a decoded micro-op, an undefined-opcode fault, or a not-recognised verdict for byte streams that belong to some other instruction.

Two side inputs shape the result. The first is the current mode, 64-bit or legacy. The second is the capability bit that enables the instruction. The result appears as a one-cycle `done` pulse, with a result kind, a 4-bit destination register index and an operand-size code alongside it. The decoder then returns to prefix collection at once, so the first byte of the next instruction can follow in the very next cycle.

Memory destinations, displacement and SIB bytes, other opcodes and execution are not handled. A memory form is reported as a fault, and any other opcode is reported as not recognised.

Top module: `seed_insn_decoder`

## Requirements
- R1: The sequence 0x0F, 0xC7 followed by a ModRM byte with mod=0b11 (bits 7:6) and reg=7 (bits 5:3) yields kind OK. The destination index is {extension bit, ModRM bits 2:0}, and the extension bit is REX bit 0 when a REX byte is in force.
- R2: The size code is 0 for 16 bits, 1 for 32 bits and 2 for 64 bits. With no prefix the size is 32 bits. A 0x66 prefix gives 16 bits. A REX byte in force with W=1 (bit 3) gives 64 bits and overrides 0x66.
- R3: Bytes 0x40..0x4F are REX prefixes only in 64-bit mode. In legacy mode such a byte in prefix position ends the instruction as not recognised, so legacy mode never gives a 64-bit size or a destination index above 7.
- R4: A REX byte is in force only if it is the last prefix before 0x0F. Any later prefix (0x66, 0xF0, 0xF2, 0xF3) cancels both of its W and B bits. A later REX byte replaces an earlier one.
- R5: A LOCK prefix (0xF0) anywhere before the opcode turns an otherwise valid instruction into kind FAULT.
- R6: A 0xF2 or 0xF3 prefix turns an otherwise valid instruction into kind FAULT.
- R7: If the feature-enable input is 0 while the ModRM byte is accepted, the result is kind FAULT.
- R8: A ModRM byte with a mod field other than 0b11 gives kind FAULT.
- R9: The result is kind NOT-RECOGNISED in three cases: a byte in prefix position that is neither a listed prefix nor 0x0F, a second opcode byte other than 0xC7, or a ModRM reg field other than 7. Not-recognised takes priority over every fault condition.
- R10: Each instruction produces exactly one `done` pulse, in the cycle after its last byte is accepted, regardless of bubbles. Kind codes are 0 idle, 1 OK, 2 FAULT and 3 NOT-RECOGNISED. Destination and size are 0 whenever `done` is low or the kind is not OK. No prefix carries over into the next instruction.
- R11: After reset `done` is 0 and kind, destination and size are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Instruction byte strobe |
| byte_in | input | 8 | Instruction byte |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| feat_en | input | 1 | Instruction enable capability bit |
| done | output | 1 | One-cycle result pulse |
| kind | output | 2 | Result kind (0 idle, 1 OK, 2 FAULT, 3 not recognised) |
| dst_idx | output | 4 | Destination register index |
| size_code | output | 2 | Operand size (0=16, 1=32, 2=64) |

## Verification
Two things happen in the same cycle. The result of one instruction is launched, and the prefix state is cleared for the next one, whose first byte arrives in the following cycle. The bench streams instructions back to back with no bubble. A faulting LOCK-prefixed instruction is followed immediately by a clean one, and REX-prefixed forms are followed by plain ones. The scoreboard then judges each pulse in order: the next instruction must show its own size and index, with no leftover fault, width or extension bit.

// File: rtl/seed_dec_pkg.sv
package seed_dec_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ESC_BYTE   = 8'h0F;
  localparam logic [BYTE_W-1:0] OPC2_BYTE  = 8'hC7;
  localparam logic [BYTE_W-1:0] OSZ_BYTE   = 8'h66;
  localparam logic [BYTE_W-1:0] LOCK_BYTE  = 8'hF0;
  localparam logic [BYTE_W-1:0] REPNZ_BYTE = 8'hF2;
  localparam logic [BYTE_W-1:0] REPZ_BYTE  = 8'hF3;
  localparam logic [3:0]        REX_NIB    = 4'h4;
  localparam logic [2:0]        SEED_EXT   = 3'd7;
  localparam logic [1:0]        MOD_REG    = 2'b11;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_OK    = 2'd1,
    K_FAULT = 2'd2,
    K_UNREC = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_32 = 2'd1,
    SZ_64 = 2'd2
  } opsz_e;

  typedef enum logic [1:0] {
    ST_PFX   = 2'd0,
    ST_OPC2  = 2'd1,
    ST_MODRM = 2'd2
  } st_e;

  typedef enum logic [2:0] {
    BC_OTHER = 3'd0,
    BC_OSZ   = 3'd1,
    BC_LOCK  = 3'd2,
    BC_REP   = 3'd3,
    BC_REX   = 3'd4,
    BC_ESC   = 3'd5
  } bclass_e;

  typedef struct packed {
    logic lock;
    logic rep;
    logic osz;
    logic rex_w;
    logic rex_b;
  } pfx_t;

endpackage

// File: rtl/seed_byte_classifier.sv
module seed_byte_classifier
  import seed_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              mode64,
  output bclass_e           cls,
  output logic              opc2_hit
);

  always_comb begin
    cls = BC_OTHER;
    if (byte_in == ESC_BYTE) begin
      cls = BC_ESC;
    end else if (byte_in == OSZ_BYTE) begin
      cls = BC_OSZ;
    end else if (byte_in == LOCK_BYTE) begin
      cls = BC_LOCK;
    end else if ((byte_in == REPNZ_BYTE) || (byte_in == REPZ_BYTE)) begin
      cls = BC_REP;
    end else if (mode64 && (byte_in[7:4] == REX_NIB)) begin
      cls = BC_REX;
    end
  end

  assign opc2_hit = (byte_in == OPC2_BYTE);

endmodule

// File: rtl/seed_prefix_tracker.sv
module seed_prefix_tracker
  import seed_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  logic    clr,
  input  bclass_e cls,
  input  logic    rex_w_bit,
  input  logic    rex_b_bit,
  output pfx_t    pfx
);

  pfx_t pfx_q;
  pfx_t pfx_d;
  logic pfx_en;

  assign pfx_en = take | clr;

  always_comb begin
    pfx_d = pfx_q;
    if (clr) begin
      pfx_d = '0;
    end else begin
      unique case (cls)
        BC_OSZ: begin
          pfx_d.osz   = 1'b1;
          pfx_d.rex_w = 1'b0;
          pfx_d.rex_b = 1'b0;
        end
        BC_LOCK: begin
          pfx_d.lock  = 1'b1;
          pfx_d.rex_w = 1'b0;
          pfx_d.rex_b = 1'b0;
        end
        BC_REP: begin
          pfx_d.rep   = 1'b1;
          pfx_d.rex_w = 1'b0;
          pfx_d.rex_b = 1'b0;
        end
        BC_REX: begin
          pfx_d.rex_w = rex_w_bit;
          pfx_d.rex_b = rex_b_bit;
        end
        default: pfx_d = pfx_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q <= '0;
    end else if (pfx_en) begin
      pfx_q <= pfx_d;
    end
  end

  assign pfx = pfx_q;

endmodule

// File: rtl/seed_seq_fsm.sv
module seed_seq_fsm
  import seed_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byte_vld,
  input  bclass_e cls,
  input  logic    opc2_hit,
  output logic    in_pfx,
  output logic    at_modrm,
  output logic    early_unrec
);

  st_e st_q;
  st_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PFX:   if (cls == BC_ESC) st_d = ST_OPC2;
      ST_OPC2:  st_d = opc2_hit ? ST_MODRM : ST_PFX;
      ST_MODRM: st_d = ST_PFX;
      default:  st_d = ST_PFX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PFX;
    end else if (byte_vld) begin
      st_q <= st_d;
    end
  end

  assign in_pfx      = (st_q == ST_PFX);
  assign at_modrm    = (st_q == ST_MODRM);
  assign early_unrec = byte_vld &
                       (((st_q == ST_PFX) && (cls == BC_OTHER)) ||
                        ((st_q == ST_OPC2) && !opc2_hit));

endmodule

// File: rtl/seed_result_former.sv
module seed_result_former
  import seed_dec_pkg::*;
#(
  parameter int RM_W  = 3,
  parameter int IDX_W = RM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              at_modrm,
  input  logic              early_unrec,
  input  pfx_t              pfx,
  input  logic              mode64,
  input  logic              feat_en,
  output logic              end_evt,
  output logic              done,
  output logic [1:0]        kind,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [1:0]        size_code
);

  logic             modrm_take;
  logic [1:0]       mod_f;
  logic [2:0]       reg_f;
  logic [RM_W-1:0]  rm_f;
  logic             bad_fault;
  kind_e            kind_d;
  opsz_e            size_d;
  logic [IDX_W-1:0] dst_d;
  logic             fld_en;

  logic             done_q;
  kind_e            kind_q;
  opsz_e            size_q;
  logic [IDX_W-1:0] dst_q;

  assign modrm_take = byte_vld & at_modrm;
  assign end_evt    = early_unrec | modrm_take;
  assign mod_f      = byte_in[7:6];
  assign reg_f      = byte_in[5:3];
  assign rm_f       = byte_in[RM_W-1:0];
  assign bad_fault  = (mod_f != MOD_REG) | pfx.lock | pfx.rep | ~feat_en;

  always_comb begin
    kind_d = K_IDLE;
    size_d = SZ_16;
    dst_d  = '0;
    if (early_unrec) begin
      kind_d = K_UNREC;
    end else if (modrm_take) begin
      if (reg_f != SEED_EXT) begin
        kind_d = K_UNREC;
      end else if (bad_fault) begin
        kind_d = K_FAULT;
      end else begin
        kind_d = K_OK;
        dst_d  = {pfx.rex_b & mode64, rm_f};
        if (pfx.rex_w && mode64) begin
          size_d = SZ_64;
        end else if (pfx.osz) begin
          size_d = SZ_16;
        end else begin
          size_d = SZ_32;
        end
      end
    end
  end

  assign fld_en = end_evt | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= end_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IDLE;
      size_q <= SZ_16;
      dst_q  <= '0;
    end else if (fld_en) begin
      kind_q <= kind_d;
      size_q <= size_d;
      dst_q  <= dst_d;
    end
  end

  assign done      = done_q;
  assign kind      = kind_q;
  assign size_code = size_q;
  assign dst_idx   = dst_q;

endmodule

// File: rtl/seed_insn_decoder.sv
module seed_insn_decoder
  import seed_dec_pkg::*;
#(
  parameter int RM_W = 3,
  localparam int IDX_W = RM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              mode64,
  input  logic              feat_en,
  output logic              done,
  output logic [1:0]        kind,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [1:0]        size_code
);

  bclass_e cls;
  logic    opc2_hit;
  logic    in_pfx;
  logic    at_modrm;
  logic    early_unrec;
  logic    end_evt;
  pfx_t    pfx;

  seed_byte_classifier u_cls (
    .byte_in  (byte_in),
    .mode64   (mode64),
    .cls      (cls),
    .opc2_hit (opc2_hit)
  );

  seed_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .cls         (cls),
    .opc2_hit    (opc2_hit),
    .in_pfx      (in_pfx),
    .at_modrm    (at_modrm),
    .early_unrec (early_unrec)
  );

  seed_prefix_tracker u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (byte_vld & in_pfx),
    .clr       (end_evt),
    .cls       (cls),
    .rex_w_bit (byte_in[3]),
    .rex_b_bit (byte_in[0]),
    .pfx       (pfx)
  );

  seed_result_former #(
    .RM_W  (RM_W),
    .IDX_W (IDX_W)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_in     (byte_in),
    .at_modrm    (at_modrm),
    .early_unrec (early_unrec),
    .pfx         (pfx),
    .mode64      (mode64),
    .feat_en     (feat_en),
    .end_evt     (end_evt),
    .done        (done),
    .kind        (kind),
    .dst_idx     (dst_idx),
    .size_code   (size_code)
  );

endmodule

// File: rtl/seed_insn_decoder_chk.sv
module seed_insn_decoder_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic [7:0]       byte_in,
  input logic             mode64,
  input logic             feat_en,
  input logic             done,
  input logic [1:0]       kind,
  input logic [IDX_W-1:0] dst_idx,
  input logic [1:0]       size_code
);

  p_done_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_vld));

  p_done_has_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (kind != 2'd0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (kind == 2'd0 && dst_idx == '0 && size_code == 2'd0));

  p_nonok_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind != 2'd1) |-> (dst_idx == '0 && size_code == 2'd0));

  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'd1) |-> (size_code != 2'd3));

  p_legacy_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'd1 && !$past(mode64)) |->
      (!dst_idx[IDX_W-1] && size_code != 2'd2));

  p_feat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind != 2'd3 && !$past(feat_en)) |-> (kind == 2'd2));

  p_mem_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind != 2'd3 && $past(byte_in[7:6]) != 2'b11) |-> (kind == 2'd2));

  p_ok_modrm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'd1) |->
      ($past(byte_in[5:3]) == 3'd7 && $past(byte_in[2:0]) == dst_idx[2:0]));

endmodule

bind seed_insn_decoder seed_insn_decoder_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_vld  (byte_vld),
  .byte_in   (byte_in),
  .mode64    (mode64),
  .feat_en   (feat_en),
  .done      (done),
  .kind      (kind),
  .dst_idx   (dst_idx),
  .size_code (size_code)
);

// File: tb/seed_insn_decoder_bench.sv
`timescale 1ns/1ps
module seed_insn_decoder_bench;

  localparam logic [1:0] OK = 2'd1, FLT = 2'd2, UNR = 2'd3;
  localparam logic [1:0] S16 = 2'd0, S32 = 2'd1, S64 = 2'd2;

  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [7:0] byte_in;
  logic       mode64;
  logic       feat_en;
  logic       done;
  logic [1:0] kind;
  logic [3:0] dst_idx;
  logic [1:0] size_code;

  int checks = 0;
  int errors = 0;
  bit run = 0;

  logic [7:0] seq[$];
  logic [1:0] q_kind[$];
  logic [3:0] q_dst[$];
  logic [1:0] q_size[$];
  string      q_tag[$];

  seed_insn_decoder u_seed_insn_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .mode64    (mode64),
    .feat_en   (feat_en),
    .done      (done),
    .kind      (kind),
    .dst_idx   (dst_idx),
    .size_code (size_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic issue(input logic m64, input logic fe, input int gap,
                       input logic [1:0] ek, input logic [3:0] ed,
                       input logic [1:0] es, input string tag);
    for (int i = 0; i < seq.size(); i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          byte_vld = 1'b0;
        end
      end
      @(negedge clk);
      mode64  = m64;
      feat_en = fe;
      if (i == seq.size() - 1) begin
        q_kind.push_back(ek);
        q_dst.push_back(ed);
        q_size.push_back(es);
        q_tag.push_back(tag);
      end
      byte_vld = 1'b1;
      byte_in  = seq[i];
    end
    seq.delete();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b0;
      byte_in  = 8'h00;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (run && rst_n && done) begin
      checks++;
      if (q_kind.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected done: kind=%0d expected no pulse", kind);
      end else begin
        logic [1:0] ek;
        logic [3:0] ed;
        logic [1:0] es;
        string      t;
        ek = q_kind.pop_front();
        ed = q_dst.pop_front();
        es = q_size.pop_front();
        t  = q_tag.pop_front();
        if (kind !== ek || dst_idx !== ed || size_code !== es) begin
          errors++;
          $display("FAIL %s: kind=%0d dst=%0d size=%0d expected kind=%0d dst=%0d size=%0d",
                   t, kind, dst_idx, size_code, ek, ed, es);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_vld = 1'b0; byte_in = 8'h00; mode64 = 1'b0; feat_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || kind !== 2'd0 || dst_idx !== 4'd0 || size_code !== 2'd0) begin
      errors++;
      $display("FAIL R11 reset: done=%0b kind=%0d dst=%0d size=%0d expected all 0",
               done, kind, dst_idx, size_code);
    end
    run = 1;

    // R1 basic legacy and 64-bit forms
    seq = '{8'h0F, 8'hC7, 8'hF8}; issue(0, 1, 0, OK, 4'd0, S32, "R1 legacy rm0");
    seq = '{8'h0F, 8'hC7, 8'hFB}; issue(1, 1, 0, OK, 4'd3, S32, "R2 mode64 default 32");
    // R2 sizes
    seq = '{8'h48, 8'h0F, 8'hC7, 8'hF9}; issue(1, 1, 0, OK, 4'd1, S64, "R2 REX.W 64");
    seq = '{8'h49, 8'h0F, 8'hC7, 8'hFA}; issue(1, 1, 0, OK, 4'd10, S64, "R1 REX.WB dst10");
    seq = '{8'h66, 8'h0F, 8'hC7, 8'hFC}; issue(0, 1, 0, OK, 4'd4, S16, "R2 0x66 16-bit");
    seq = '{8'h66, 8'h48, 8'h0F, 8'hC7, 8'hF8}; issue(1, 1, 0, OK, 4'd0, S64, "R2 REX.W over 0x66");
    seq = '{8'h41, 8'h0F, 8'hC7, 8'hFD}; issue(1, 1, 0, OK, 4'd13, S32, "R1 REX.B dst13");
    // R3 legacy REX-like byte
    seq = '{8'h48}; issue(0, 1, 0, UNR, 4'd0, S16, "R3 legacy 0x48");
    seq = '{8'h0F, 8'hC7, 8'hFF}; issue(0, 1, 0, OK, 4'd7, S32, "R3 legacy after 0x48");
    // R4 REX cancellation and replacement
    seq = '{8'h49, 8'h66, 8'h0F, 8'hC7, 8'hFA}; issue(1, 1, 0, OK, 4'd2, S16, "R4 REX cancelled by 0x66");
    seq = '{8'h48, 8'h41, 8'h0F, 8'hC7, 8'hF8}; issue(1, 1, 0, OK, 4'd8, S32, "R4 later REX replaces");
    // R5 LOCK, back-to-back clean instruction (R10)
    seq = '{8'hF0, 8'h0F, 8'hC7, 8'hF8}; issue(1, 1, 0, FLT, 4'd0, S16, "R5 LOCK fault");
    seq = '{8'h0F, 8'hC7, 8'hF9}; issue(1, 1, 0, OK, 4'd1, S32, "R10 no LOCK carry-over");
    // R6 repeat prefixes
    seq = '{8'hF2, 8'h0F, 8'hC7, 8'hF8}; issue(1, 1, 0, FLT, 4'd0, S16, "R6 F2 fault");
    seq = '{8'hF3, 8'h0F, 8'hC7, 8'hF8}; issue(0, 1, 0, FLT, 4'd0, S16, "R6 F3 fault");
    // R7 feature disabled
    seq = '{8'h0F, 8'hC7, 8'hF8}; issue(1, 0, 0, FLT, 4'd0, S16, "R7 feature off");
    // R8 memory forms
    seq = '{8'h0F, 8'hC7, 8'h38}; issue(1, 1, 0, FLT, 4'd0, S16, "R8 mod00");
    seq = '{8'h0F, 8'hC7, 8'h79}; issue(0, 1, 0, FLT, 4'd0, S16, "R8 mod01");
    // R9 not recognised
    seq = '{8'h90}; issue(1, 1, 0, UNR, 4'd0, S16, "R9 other first byte");
    seq = '{8'h0F, 8'h31}; issue(1, 1, 0, UNR, 4'd0, S16, "R9 other second byte");
    seq = '{8'h0F, 8'hC7, 8'hF0}; issue(1, 1, 0, UNR, 4'd0, S16, "R9 reg6");
    seq = '{8'hF0, 8'h0F, 8'hC7, 8'h08}; issue(1, 0, 0, UNR, 4'd0, S16, "R9 unrec over faults");
    // R10 bubbles, REX not carried into next instruction
    seq = '{8'h49, 8'h0F, 8'hC7, 8'hFE}; issue(1, 1, 2, OK, 4'd14, S64, "R10 with bubbles");
    seq = '{8'h0F, 8'hC7, 8'hFE}; issue(1, 1, 0, OK, 4'd6, S32, "R10 no REX carry-over");
    seq = '{8'h66, 8'h0F, 8'hC7, 8'hFB}; issue(1, 1, 1, OK, 4'd3, S16, "R2 0x66 in mode64");

    idle(4);
    checks++;
    if (q_kind.size() != 0) begin
      errors++;
      $display("FAIL R10 missing pulses: %0d pending expected 0", q_kind.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule